// File: doc/BRIEF.md
# 8-bit Up/Down Timer Counter Unit

This block holds the count register of an 8-bit timer together with its compare register and the control logic around them. A strobe from an external clock-select stage tells it when to advance. On each strobe the count is cleared, incremented or decremented, as the control inputs decide. The unit flags when the count sits at its upper limit or at zero, and it keeps an overflow flag and a compare-match flag. Software clears either flag by writing a one to it.

The upper limit of the count is either the fixed all-ones value or the active compare value, picked by an input. The compare value is double buffered. Software writes a buffer, and a mode input decides when that buffer reaches the active compare register: at once, when the count is at the upper limit, or when the count is at zero. A software load of the count always wins over a clear or count strobe in the same cycle.

Top module: `tmr8_count_unit`

## Requirements
- R1: After reset the count, the active compare value, the compare buffer and both flags are zero.
- R2: When `cnt_wr_i` is high, the count takes `wdata_i` on the next edge, whatever `tick_i`, `clr_i` and `dir_down_i` are.
- R3: With `tick_i` low and no count write, the count keeps its value.
- R4: On a tick without a count write, `clr_i`=1 loads 0x00. Otherwise `dir_down_i`=1 decrements, so 0x00 goes to 0xFF. With `dir_down_i`=0 the count increments, but goes to 0x00 when the count equals the upper limit.
- R5: The upper limit is 0xFF when `top_sel_i`=0 and the active compare value when `top_sel_i`=1. `at_top_o` is high in the same cycle that the count equals the upper limit. `at_bottom_o` is high in the same cycle that the count is 0x00.
- R6: `ovf_flag_o` sets after a tick with no count write, no clear and `dir_down_i`=0 while the count is 0xFF.
- R7: `cmp_flag_o` sets after a tick with no count write while the count equals the active compare value.
- R8: Writing a one to `flag_clr_i[0]` clears the overflow flag, and a one to `flag_clr_i[1]` clears the compare flag. If the flag's set event happens in the same cycle, the flag stays set.
- R9: With `buf_mode_i` = 0 or 3, `cmp_wr_i` loads `wdata_i` into the buffer and into the active compare value on the same edge.
- R10: With `buf_mode_i`=1, the active compare value takes the buffer on a tick while the count is at the upper limit. With `buf_mode_i`=2, it takes the buffer on a tick while the count is 0x00. In both modes a compare write changes only the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count strobe from clock select |
| dir_down_i | input | 1 | 1 = count down, 0 = count up |
| clr_i | input | 1 | Clear count on tick |
| top_sel_i | input | 1 | 0 = limit 0xFF, 1 = limit is active compare |
| buf_mode_i | input | 2 | Compare update: 0/3 immediate, 1 at limit, 2 at zero |
| cnt_wr_i | input | 1 | Software load of the count |
| cmp_wr_i | input | 1 | Software write of the compare buffer |
| wdata_i | input | 8 | Write data for both writes |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| cnt_o | output | 8 | Current count |
| cmp_o | output | 8 | Active compare value |
| at_top_o | output | 1 | Count equals upper limit |
| at_bottom_o | output | 1 | Count equals zero |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare-match flag |

## Verification
The two collisions of interest are a software count load landing on a tick with a clear, and a flag clear landing on the cycle that sets the same flag. The bench forces both with directed sequences: a load together with tick and clear, and a compare-flag clear issued on a tick where the count equals the compare value. Random stimulus also brings them together often, because each control is drawn independently. A bench model derived from the requirements gives the expected value after each edge, so the load must win and the flag must stay set.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    typedef enum logic [1:0] {
        BUF_NOW   = 2'd0,
        BUF_TOP   = 2'd1,
        BUF_BOT   = 2'd2,
        BUF_NOW_B = 2'd3
    } buf_mode_e;

    localparam int FLAG_OVF = 0;
    localparam int FLAG_CMP = 1;
    localparam int NFLAGS   = 2;
endpackage

// File: rtl/tmr8_cnt_core.sv
module tmr8_cnt_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         dir_down_i,
    input  logic         clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] top_val_i,
    output logic [W-1:0] cnt_o,
    output logic         at_top_o,
    output logic         at_bottom_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
    } core_st_t;

    core_st_t st_q, st_d;

    assign cnt_o       = st_q.cnt;
    assign at_top_o    = (st_q.cnt == top_val_i);
    assign at_bottom_o = (st_q.cnt == ZERO);
    assign wrap_o      = tick_i && !wr_i && !clr_i && !dir_down_i && (st_q.cnt == MAXV);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (tick_i) begin
            if (clr_i)
                st_d.cnt = ZERO;
            else if (dir_down_i)
                st_d.cnt = st_q.cnt - 1'b1;
            else if (at_top_o)
                st_d.cnt = ZERO;
            else
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_wr_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wdata_i)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(cnt_o));
    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && clr_i && !wr_i) |=> (cnt_o == ZERO));
    p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && dir_down_i && !clr_i && !wr_i) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/tmr8_cmp_buf.sv
module tmr8_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         tick_i,
    input  logic         at_top_i,
    input  logic         at_bottom_i,
    output logic [W-1:0] act_o
);
    import tmr8_pkg::*;

    typedef struct packed {
        logic [W-1:0] bufv;
        logic [W-1:0] act;
    } cmp_st_t;

    cmp_st_t   st_q, st_d;
    buf_mode_e mode;

    assign mode  = buf_mode_e'(mode_i);
    assign act_o = st_q.act;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.bufv = wdata_i;
        case (mode)
            BUF_TOP: if (tick_i && at_top_i)    st_d.act = st_q.bufv;
            BUF_BOT: if (tick_i && at_bottom_i) st_d.act = st_q.bufv;
            default: if (wr_i)                  st_d.act = wdata_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_imm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> (act_o == $past(wdata_i)));
    p_buf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && (mode_i == 2'd1 || mode_i == 2'd2)) |=> $stable(act_o));
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
    parameter int W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic                        cnt_wr_i,
    input  logic [W-1:0]                cnt_i,
    input  logic [W-1:0]                cmp_i,
    input  logic                        wrap_i,
    input  logic [tmr8_pkg::NFLAGS-1:0] clr_i,
    output logic                        ovf_o,
    output logic                        cmp_o
);
    import tmr8_pkg::*;

    typedef struct packed {
        logic ovf;
        logic cf;
    } flag_st_t;

    flag_st_t st_q, st_d;
    logic     match;

    assign match = tick_i && !cnt_wr_i && (cnt_i == cmp_i);
    assign ovf_o = st_q.ovf;
    assign cmp_o = st_q.cf;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = wrap_i || (st_q.ovf && !clr_i[FLAG_OVF]);
        st_d.cf  = match  || (st_q.cf  && !clr_i[FLAG_CMP]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> ovf_o);
    p_cmp_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && cnt_i == cmp_i) |=> cmp_o);
    p_ovf_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[FLAG_OVF] && !wrap_i) |=> !ovf_o);
endmodule

// File: rtl/tmr8_count_unit.sv
module tmr8_count_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         dir_down_i,
    input  logic         clr_i,
    input  logic         top_sel_i,
    input  logic [1:0]   buf_mode_i,
    input  logic         cnt_wr_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [1:0]   flag_clr_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmp_o,
    output logic         at_top_o,
    output logic         at_bottom_o,
    output logic         ovf_flag_o,
    output logic         cmp_flag_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] act_cmp;
    logic [W-1:0] top_val;
    logic         wrap;

    assign top_val = top_sel_i ? act_cmp : MAXV;
    assign cmp_o   = act_cmp;

    tmr8_cnt_core #(.W(W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .dir_down_i  (dir_down_i),
        .clr_i       (clr_i),
        .wr_i        (cnt_wr_i),
        .wdata_i     (wdata_i),
        .top_val_i   (top_val),
        .cnt_o       (cnt_o),
        .at_top_o    (at_top_o),
        .at_bottom_o (at_bottom_o),
        .wrap_o      (wrap)
    );

    tmr8_cmp_buf #(.W(W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (buf_mode_i),
        .wr_i        (cmp_wr_i),
        .wdata_i     (wdata_i),
        .tick_i      (tick_i),
        .at_top_i    (at_top_o),
        .at_bottom_i (at_bottom_o),
        .act_o       (act_cmp)
    );

    tmr8_flags #(.W(W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .cnt_wr_i (cnt_wr_i),
        .cnt_i    (cnt_o),
        .cmp_i    (act_cmp),
        .wrap_i   (wrap),
        .clr_i    (flag_clr_i),
        .ovf_o    (ovf_flag_o),
        .cmp_o    (cmp_flag_o)
    );

    p_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_sel_i && cnt_o == MAXV) |-> at_top_o);
    p_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        at_bottom_o |-> (cnt_o == '0));
endmodule

// File: tb/tb_tmr8_count_unit.sv
`timescale 1ns/1ps
module tb_tmr8_count_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick, down, clr, tsel, cw, mw;
    logic [1:0] mode, fclr;
    logic [7:0] wd;
    logic [7:0] cnt_o, cmp_o;
    logic       at_top, at_bot, ovf, cf;

    logic [7:0] m_cnt, m_act, m_buf;
    logic       m_ovf, m_cf;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #4 clk = ~clk;

    tmr8_count_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dir_down_i(down), .clr_i(clr),
        .top_sel_i(tsel), .buf_mode_i(mode), .cnt_wr_i(cw), .cmp_wr_i(mw),
        .wdata_i(wd), .flag_clr_i(fclr), .cnt_o(cnt_o), .cmp_o(cmp_o),
        .at_top_o(at_top), .at_bottom_o(at_bot), .ovf_flag_o(ovf), .cmp_flag_o(cf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_top();
        return tsel ? m_act : 8'hFF;
    endfunction

    task automatic chk_all();
        chk("R4 count vs model", cnt_o, m_cnt);
        chk("R10 compare vs model", cmp_o, m_act);
        chk("R5 at_top", at_top, (m_cnt == m_top()));
        chk("R5 at_bottom", at_bot, (m_cnt == 8'h00));
        chk("R6 overflow flag", ovf, m_ovf);
        chk("R7 compare flag", cf, m_cf);
    endtask

    task automatic drive(input logic t, input logic dn, input logic c, input logic ts,
                         input logic [1:0] md, input logic cwr, input logic mwr,
                         input logic [7:0] d, input logic [1:0] fc);
        tick = t; down = dn; clr = c; tsel = ts; mode = md;
        cw = cwr; mw = mwr; wd = d; fclr = fc;
    endtask

    task automatic step();
        logic [7:0] n_cnt, n_act, n_buf;
        logic       wrap, match, n_ovf, n_cf;
        n_cnt = m_cnt;
        if (cw) n_cnt = wd;
        else if (tick) begin
            if (clr)                     n_cnt = 8'h00;
            else if (down)               n_cnt = m_cnt - 8'h01;
            else if (m_cnt == m_top())   n_cnt = 8'h00;
            else                         n_cnt = m_cnt + 8'h01;
        end
        wrap  = tick && !cw && !clr && !down && (m_cnt == 8'hFF);
        match = tick && !cw && (m_cnt == m_act);
        n_ovf = wrap  || (m_ovf && !fclr[0]);
        n_cf  = match || (m_cf  && !fclr[1]);
        n_buf = mw ? wd : m_buf;
        n_act = m_act;
        if (mode == 2'd1)      begin if (tick && m_cnt == m_top()) n_act = m_buf; end
        else if (mode == 2'd2) begin if (tick && m_cnt == 8'h00)   n_act = m_buf; end
        else if (mw)           n_act = wd;
        @(posedge clk);
        @(negedge clk);
        m_cnt = n_cnt; m_act = n_act; m_buf = n_buf; m_ovf = n_ovf; m_cf = n_cf;
        chk_all();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        drive(0, 0, 0, 0, 2'd0, 0, 0, 8'h00, 2'b00);
        m_cnt = 0; m_act = 0; m_buf = 0; m_ovf = 0; m_cf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", cnt_o, 0);
        chk("R1 reset compare", cmp_o, 0);
        chk("R1 reset overflow flag", ovf, 0);
        chk("R1 reset compare flag", cf, 0);

        // R2: load wins over tick with clear
        drive(1, 0, 1, 0, 2'd0, 1, 0, 8'hFE, 2'b00); step();
        chk("R2 load beats clear", cnt_o, 8'hFE);
        // R3: no tick holds
        drive(0, 0, 0, 0, 2'd0, 0, 0, 8'h55, 2'b00); step(); step();
        chk("R3 hold", cnt_o, 8'hFE);
        // R4/R6: count up through 0xFF
        drive(1, 0, 0, 0, 2'd0, 0, 0, 8'h00, 2'b00); step();
        chk("R4 up to FF", cnt_o, 8'hFF);
        chk("R5 at_top at FF", at_top, 1);
        step();
        chk("R4 wrap to 00", cnt_o, 8'h00);
        chk("R6 overflow set", ovf, 1);
        // R8: clear overflow
        drive(0, 0, 0, 0, 2'd0, 0, 0, 8'h00, 2'b01); step();
        chk("R8 overflow cleared", ovf, 0);
        // R4: down from 0
        drive(1, 1, 0, 0, 2'd0, 0, 0, 8'h00, 2'b00); step();
        chk("R4 down wraps to FF", cnt_o, 8'hFF);
        chk("R6 no overflow on down", ovf, 0);
        // R9: immediate compare write
        drive(0, 0, 0, 0, 2'd0, 0, 1, 8'h10, 2'b00); step();
        chk("R9 immediate compare", cmp_o, 8'h10);
        // R5/R7: limit from compare
        drive(0, 0, 0, 1, 2'd0, 1, 0, 8'h0F, 2'b00); step();
        drive(1, 0, 0, 1, 2'd0, 0, 0, 8'h00, 2'b00); step();
        chk("R5 at_top at compare limit", at_top, 1);
        step();
        chk("R4 wrap at compare limit", cnt_o, 8'h00);
        chk("R7 compare flag set", cf, 1);
        chk("R5 at_bottom", at_bot, 1);
        // R10: buffered at limit
        drive(0, 0, 0, 1, 2'd1, 0, 1, 8'h03, 2'b00); step();
        chk("R10 buffered write held", cmp_o, 8'h10);
        drive(1, 0, 0, 1, 2'd1, 0, 0, 8'h00, 2'b00);
        for (int i = 0; i < 16; i++) step();
        chk("R10 not yet at limit", cmp_o, 8'h10);
        step();
        chk("R10 update at limit", cmp_o, 8'h03);
        // R8: set beats clear
        drive(0, 0, 0, 1, 2'd1, 1, 0, 8'h03, 2'b10); step();
        chk("R8 compare flag cleared", cf, 0);
        drive(1, 0, 0, 1, 2'd1, 0, 0, 8'h00, 2'b10); step();
        chk("R8 set wins over clear", cf, 1);
        // R10: buffered at bottom
        drive(0, 0, 0, 1, 2'd2, 0, 1, 8'h40, 2'b00); step();
        chk("R10 bottom-mode write held", cmp_o, 8'h03);
        drive(1, 0, 0, 1, 2'd2, 0, 0, 8'h00, 2'b00); step();
        chk("R10 update at bottom", cmp_o, 8'h40);

        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) begin
                tsel = 1'($urandom);
                mode = 2'($urandom);
            end
            tick = 1'($urandom);
            down = (($urandom % 4) == 0);
            clr  = (($urandom % 16) == 0);
            cw   = (($urandom % 16) == 0);
            mw   = (($urandom % 8) == 0);
            wd   = 8'($urandom);
            fclr = {(($urandom % 8) == 0), (($urandom % 8) == 0)};
            step();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule